// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block gathers up to 32 interrupt inputs into one interrupt line for a processor. Each input can be set to respond to a rising edge, a falling edge, a high level or a low level. When an input fires, a bit in a pending register is set. Software reads that register through a small 32-bit register port and clears bits by writing ones to them. An enable mask picks which pending bits reach the combined line. The line can be driven as a level or as a one-clock pulse, with either polarity.

A force register lets software set pending bits directly, so that the interrupt path can be exercised without toggling the real inputs. Register reads are combinational from the address. A write takes effect at the clock edge where `wr_en` is high.

A typical start-up sequence first clears the enable mask and the two output control registers to zero. It then writes the trigger settings and writes all ones to the pending register, which discards events that were latched while the trigger settings were changing.

Top module: `trig_intc`

## Requirements
- R1: After reset, the enable, source-mode, source-polarity, output-mode and output-polarity registers read zero, and `irq_out` is high (active-low level output with nothing enabled).
- R2: Registers sit at byte offsets: enable 0x00, pending 0x04, source mode 0x08, source polarity 0x0C, output mode 0x10, output polarity 0x14, force 0x18. Output mode and output polarity use bit 0 only and read zero in bits 31:1.
- R3: A source with {mode,polarity} = 11 (rising edge) sets its pending bit at the clock edge after its input goes from 0 to 1 (compared with the input registered on the previous edge). A 1-to-0 change does not set it.
- R4: A source with {mode,polarity} = 10 (falling edge) sets its pending bit on a 1-to-0 input change, and not on a 0-to-1 change.
- R5: A source with mode 0 is level-sensitive: polarity 1 means active-high and polarity 0 means active-low. Its pending bit is set on every edge where the level is active, so a one-write cannot clear it while the level stays active. After reset, with all settings at zero and inputs low, every pending bit becomes set.
- R6: Writing a 1 to a pending bit clears it unless the same edge sets it again. Writing 0 leaves it unchanged. Without a write to the pending register, a set bit stays set.
- R7: The combined request is the OR of pending AND enable. Pending bits whose enable bit is 0 have no effect on `irq_out`.
- R8: With output mode 0, `irq_out` is a level: output polarity 1 makes it high while a request exists, and polarity 0 makes it low while a request exists.
- R9: With output mode 1, `irq_out` is active for exactly one clock after an edge that makes an enabled pending bit newly set. It is idle otherwise, and output polarity selects the active level.
- R10: Writing ones to the force register sets the matching pending bits at that edge. The force register always reads zero.
- R11: Reads from any other offset (including misaligned ones) return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, taken at the rising clock edge |
| addr | input | AW (8) | Register byte offset for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| src_in | input | NSRC (32) | Raw interrupt source inputs, one bit per source |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The bound checker watches every cycle for these properties:
- level-active and edge events always leave their pending bits set on the next edge;
- pending bits never drop without a write to the pending register;
- the force and unmapped offsets read zero;
- every pulse-mode output has a newly set enabled bit behind it;
- with an empty enable mask, an active-high level output stays low.

The rules that involve whole sequences can only be shown by the directed scenarios:
- a one-write failing to clear an active level;
- falling-edge sources ignoring rises;
- the pulse lasting exactly one clock;
- polarity inversion of the output;
- writes to unmapped offsets leaving the real registers untouched.

// File: rtl/trig_intc_pkg.sv
package trig_intc_pkg;

    localparam logic [31:0] OFF_ENABLE = 32'h00;
    localparam logic [31:0] OFF_PEND   = 32'h04;
    localparam logic [31:0] OFF_SMODE  = 32'h08;
    localparam logic [31:0] OFF_SPOL   = 32'h0C;
    localparam logic [31:0] OFF_OMODE  = 32'h10;
    localparam logic [31:0] OFF_OPOL   = 32'h14;
    localparam logic [31:0] OFF_FORCE  = 32'h18;

    // Per-source trigger kind, encoded as {mode, polarity}
    typedef enum logic [1:0] {
        TRIG_LEVEL_LOW  = 2'b00,
        TRIG_LEVEL_HIGH = 2'b01,
        TRIG_EDGE_FALL  = 2'b10,
        TRIG_EDGE_RISE  = 2'b11
    } trig_t;

    typedef enum logic [2:0] {
        RID_ENABLE, RID_PEND, RID_SMODE, RID_SPOL,
        RID_OMODE, RID_OPOL, RID_FORCE, RID_NONE
    } reg_id_t;

    typedef struct packed {
        logic pulse_mode;   // 1: one-clock pulse, 0: level
        logic active_high;  // 1: active-high, 0: active-low
    } out_cfg_t;

    function automatic reg_id_t decode_off(input logic [31:0] off);
        case (off)
            OFF_ENABLE: return RID_ENABLE;
            OFF_PEND:   return RID_PEND;
            OFF_SMODE:  return RID_SMODE;
            OFF_SPOL:   return RID_SPOL;
            OFF_OMODE:  return RID_OMODE;
            OFF_OPOL:   return RID_OPOL;
            OFF_FORCE:  return RID_FORCE;
            default:    return RID_NONE;
        endcase
    endfunction

    function automatic logic src_hit(input trig_t kind, input logic now, input logic prev);
        case (kind)
            TRIG_EDGE_RISE:  return now & ~prev;
            TRIG_EDGE_FALL:  return ~now & prev;
            TRIG_LEVEL_HIGH: return now;
            default:         return ~now;
        endcase
    endfunction

endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
    import trig_intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  reg_id_t         rid,
    input  logic [31:0]     wr_data,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] smode_q,
    output logic [NSRC-1:0] spol_q,
    output out_cfg_t        ocfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            smode_q <= '0;
            spol_q  <= '0;
            ocfg_q  <= '0;
        end else if (wr_en) begin
            case (rid)
                RID_ENABLE: en_q               <= wr_data[NSRC-1:0];
                RID_SMODE:  smode_q            <= wr_data[NSRC-1:0];
                RID_SPOL:   spol_q             <= wr_data[NSRC-1:0];
                RID_OMODE:  ocfg_q.pulse_mode  <= wr_data[0];
                RID_OPOL:   ocfg_q.active_high <= wr_data[0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/intc_trigger.sv
module intc_trigger
    import trig_intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] smode,
    input  logic [NSRC-1:0] spol,
    output logic [NSRC-1:0] hit
);

    // Previous-edge copy of the inputs; loaded during reset too so that
    // edge comparison is meaningful from the first cycle after reset.
    logic [NSRC-1:0] src_q;

    always_ff @(posedge clk) begin
        src_q <= src_in;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = src_hit(trig_t'({smode[g], spol[g]}), src_in[g], src_q[g]);
    end

endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] clr_vec,
    output logic [NSRC-1:0] pend_q
);

    // Setting wins over clearing in the same cycle
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

endmodule

// File: rtl/intc_out_drive.sv
module intc_out_drive
    import trig_intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en,
    input  out_cfg_t        ocfg,
    output logic            irq_out
);

    logic [NSRC-1:0] masked;
    logic [NSRC-1:0] masked_q;
    logic            fresh;
    logic            active;

    assign masked = pend & en;

    always_ff @(posedge clk) begin
        if (rst) masked_q <= '0;
        else     masked_q <= masked;
    end

    assign fresh   = |(masked & ~masked_q);
    assign active  = ocfg.pulse_mode ? fresh : |masked;
    assign irq_out = ocfg.active_high ? active : ~active;

endmodule

// File: rtl/trig_intc.sv
module trig_intc
    import trig_intc_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [31:0]     wr_data,
    output logic [31:0]     rd_data,
    input  logic [NSRC-1:0] src_in,
    output logic            irq_out
);

    reg_id_t         rid;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] smode_q;
    logic [NSRC-1:0] spol_q;
    out_cfg_t        ocfg_q;
    logic [NSRC-1:0] hit;
    logic [NSRC-1:0] force_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] pend_q;

    assign rid       = decode_off(32'(addr));
    assign clr_vec   = (wr_en && rid == RID_PEND)  ? wr_data[NSRC-1:0] : '0;
    assign force_vec = (wr_en && rid == RID_FORCE) ? wr_data[NSRC-1:0] : '0;

    intc_cfg_regs #(.NSRC(NSRC)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rid     (rid),
        .wr_data (wr_data),
        .en_q    (en_q),
        .smode_q (smode_q),
        .spol_q  (spol_q),
        .ocfg_q  (ocfg_q)
    );

    intc_trigger #(.NSRC(NSRC)) u_trig (
        .clk    (clk),
        .src_in (src_in),
        .smode  (smode_q),
        .spol   (spol_q),
        .hit    (hit)
    );

    intc_pending #(.NSRC(NSRC)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_vec (hit | force_vec),
        .clr_vec (clr_vec),
        .pend_q  (pend_q)
    );

    intc_out_drive #(.NSRC(NSRC)) u_out (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend_q),
        .en      (en_q),
        .ocfg    (ocfg_q),
        .irq_out (irq_out)
    );

    always_comb begin
        rd_data = '0;
        case (rid)
            RID_ENABLE: rd_data = 32'(en_q);
            RID_PEND:   rd_data = 32'(pend_q);
            RID_SMODE:  rd_data = 32'(smode_q);
            RID_SPOL:   rd_data = 32'(spol_q);
            RID_OMODE:  rd_data = {31'd0, ocfg_q.pulse_mode};
            RID_OPOL:   rd_data = {31'd0, ocfg_q.active_high};
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/trig_intc_checker.sv
module trig_intc_checker #(
    parameter int NSRC = 32,
    parameter int AW   = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [AW-1:0]   addr,
    input logic [31:0]     rd_data,
    input logic [NSRC-1:0] src_in,
    input logic            irq_out,
    input logic [NSRC-1:0] pend_q,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] smode_q,
    input logic [NSRC-1:0] spol_q,
    input logic            omode,
    input logic            opol
);

    logic [NSRC-1:0] src_prev;
    logic [NSRC-1:0] lvl_act;
    logic [NSRC-1:0] rise_ev;
    logic [NSRC-1:0] fall_ev;
    logic [NSRC-1:0] vis;

    always_ff @(posedge clk) begin
        src_prev <= src_in;
    end

    assign lvl_act = ~smode_q & ~(src_in ^ spol_q);
    assign rise_ev = smode_q & spol_q & src_in & ~src_prev;
    assign fall_ev = smode_q & ~spol_q & ~src_in & src_prev;
    assign vis     = pend_q & en_q;

    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(lvl_act)) == $past(lvl_act))); // R5

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(rise_ev)) == $past(rise_ev))); // R3

    AST_FALL_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(fall_ev)) == $past(fall_ev))); // R4

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == AW'(8'h04)) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R6

    AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr == AW'(8'h18)) |-> (rd_data == 32'd0)); // R10

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((addr > AW'(8'h18)) || (addr[1:0] != 2'b00)) |-> (rd_data == 32'd0)); // R11

    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (omode && opol && irq_out) |-> (|(vis & ~$past(vis)))); // R9

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!omode && opol && en_q == '0) |-> !irq_out); // R7

endmodule

bind trig_intc trig_intc_checker #(.NSRC(NSRC), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .rd_data (rd_data),
    .src_in  (src_in),
    .irq_out (irq_out),
    .pend_q  (pend_q),
    .en_q    (en_q),
    .smode_q (smode_q),
    .spol_q  (spol_q),
    .omode   (ocfg_q.pulse_mode),
    .opol    (ocfg_q.active_high)
);

// File: tb/tb_trig_intc.sv
module tb_trig_intc;

    localparam logic [7:0] A_EN    = 8'h00;
    localparam logic [7:0] A_PEND  = 8'h04;
    localparam logic [7:0] A_SMODE = 8'h08;
    localparam logic [7:0] A_SPOL  = 8'h0C;
    localparam logic [7:0] A_OMODE = 8'h10;
    localparam logic [7:0] A_OPOL  = 8'h14;
    localparam logic [7:0] A_FORCE = 8'h18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data;
    logic [31:0] src_in = 32'd0;
    logic        irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    trig_intc dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .src_in  (src_in),
        .irq_out (irq_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'd0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_in = v;
        @(negedge clk);
    endtask

    // All sources rising edge, nothing pending, output level active-low
    task automatic init_edges();
        src_in = 32'd0;
        wr(A_EN, 32'd0);
        wr(A_OMODE, 32'd0);
        wr(A_OPOL, 32'd0);
        wr(A_SMODE, 32'hFFFF_FFFF);
        wr(A_SPOL, 32'hFFFF_FFFF);
        wr(A_PEND, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_EN, d);    chk("R1 enable after reset", d, 32'd0);
        rd(A_SMODE, d); chk("R1 source mode after reset", d, 32'd0);
        rd(A_SPOL, d);  chk("R1 source polarity after reset", d, 32'd0);
        rd(A_OMODE, d); chk("R1 output mode after reset", d, 32'd0);
        rd(A_OPOL, d);  chk("R1 output polarity after reset", d, 32'd0);
        chk("R1 irq_out idle high", {31'd0, irq_out}, 32'd1);
        @(negedge clk);
        rd(A_PEND, d);  chk("R5 low-level default sets all pending", d, 32'hFFFF_FFFF);
        chk("R7 masked pending keeps irq_out idle", {31'd0, irq_out}, 32'd1);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        init_edges();
        wr(A_EN, 32'hA5A5_0F0F);
        rd(A_EN, d);    chk("R2 enable readback", d, 32'hA5A5_0F0F);
        rd(A_SMODE, d); chk("R2 source mode readback", d, 32'hFFFF_FFFF);
        wr(A_OMODE, 32'hFFFF_FFFE);
        rd(A_OMODE, d); chk("R2 output mode bit0 only", d, 32'd0);
        wr(A_OPOL, 32'hFFFF_FFFF);
        rd(A_OPOL, d);  chk("R2 output polarity bit0 only", d, 32'd1);
        wr(A_EN, 32'd0);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        init_edges();
        rd(A_PEND, d); chk("R6 init clears pending", d, 32'd0);
        set_src(32'h0000_0008);
        rd(A_PEND, d); chk("R3 rising edge sets bit3", d, 32'h0000_0008);
        set_src(32'd0);
        rd(A_PEND, d); chk("R3 fall ignored on rising source", d, 32'h0000_0008);
        wr(A_PEND, 32'd0);
        rd(A_PEND, d); chk("R6 zero write keeps pending", d, 32'h0000_0008);
        wr(A_PEND, 32'h0000_0008);
        rd(A_PEND, d); chk("R6 one write clears pending", d, 32'd0);
    endtask

    task automatic t_fall();
        logic [31:0] d;
        init_edges();
        wr(A_SPOL, ~32'h0000_0020);
        set_src(32'h0000_0020);
        rd(A_PEND, d); chk("R4 rise ignored on falling source", d, 32'd0);
        set_src(32'd0);
        rd(A_PEND, d); chk("R4 falling edge sets bit5", d, 32'h0000_0020);
    endtask

    task automatic t_level();
        logic [31:0] d;
        init_edges();
        wr(A_SMODE, ~32'h0000_0080);
        rd(A_PEND, d); chk("R5 inactive high level leaves pending", d, 32'd0);
        set_src(32'h0000_0080);
        rd(A_PEND, d); chk("R5 high level sets bit7", d, 32'h0000_0080);
        wr(A_PEND, 32'h0000_0080);
        rd(A_PEND, d); chk("R5 clear refused while level active", d, 32'h0000_0080);
        set_src(32'd0);
        rd(A_PEND, d); chk("R5 bit7 stays after level drops", d, 32'h0000_0080);
        wr(A_PEND, 32'h0000_0080);
        rd(A_PEND, d); chk("R5 clear after level drops", d, 32'd0);
        wr(A_SMODE, ~32'h0000_0180);
        wr(A_SPOL, ~32'h0000_0100);
        @(negedge clk);
        rd(A_PEND, d); chk("R5 low level with input low sets bit8", d, 32'h0000_0100);
        set_src(32'h0000_0100);
        wr(A_PEND, 32'h0000_0100);
        rd(A_PEND, d); chk("R5 low level cleared once input high", d, 32'd0);
    endtask

    task automatic t_out();
        init_edges();
        set_src(32'h0000_0008);
        set_src(32'd0);
        chk("R7 pending with enable 0 stays idle", {31'd0, irq_out}, 32'd1);
        wr(A_EN, 32'h0000_0010);
        chk("R7 other enable bit stays idle", {31'd0, irq_out}, 32'd1);
        wr(A_EN, 32'h0000_0008);
        chk("R8 active-low level asserted", {31'd0, irq_out}, 32'd0);
        wr(A_OPOL, 32'd1);
        chk("R8 active-high level asserted", {31'd0, irq_out}, 32'd1);
        wr(A_EN, 32'd0);
        chk("R7 disable drops active-high level", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_pulse();
        init_edges();
        wr(A_OMODE, 32'd1);
        wr(A_OPOL, 32'd1);
        wr(A_EN, 32'h0000_0008);
        chk("R9 pulse idle low", {31'd0, irq_out}, 32'd0);
        set_src(32'h0000_0008);
        chk("R9 pulse on new pending", {31'd0, irq_out}, 32'd1);
        @(negedge clk);
        chk("R9 pulse lasts one clock", {31'd0, irq_out}, 32'd0);
        set_src(32'd0);
        wr(A_OPOL, 32'd0);
        chk("R9 active-low pulse idle high", {31'd0, irq_out}, 32'd1);
        wr(A_FORCE, 32'h0000_0010);
        chk("R9 masked new pending gives no pulse", {31'd0, irq_out}, 32'd1);
    endtask

    task automatic t_force();
        logic [31:0] d;
        init_edges();
        wr(A_FORCE, 32'h0000_0400);
        rd(A_PEND, d);  chk("R10 force sets bit10", d, 32'h0000_0400);
        rd(A_FORCE, d); chk("R10 force reads zero", d, 32'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        init_edges();
        wr(A_EN, 32'h0000_0055);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(A_EN, d);    chk("R11 unmapped writes keep enable", d, 32'h0000_0055);
        rd(A_PEND, d);  chk("R11 unmapped writes keep pending", d, 32'd0);
        rd(A_OPOL, d);  chk("R11 unmapped writes keep output polarity", d, 32'd0);
        rd(8'h1C, d);   chk("R11 read 0x1C is zero", d, 32'd0);
        rd(8'h02, d);   chk("R11 misaligned read is zero", d, 32'd0);
        rd(8'h40, d);   chk("R11 read 0x40 is zero", d, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_rise();
        t_fall();
        t_level();
        t_out();
        t_pulse();
        t_force();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule